// File: doc/BRIEF.md
# Serial EEPROM Target with Page-Buffered Writes

This block is a two-wire bus target that looks to a bus master like a small serial EEPROM. It oversamples the clock and data lines with the system clock. It answers on the data line only by pulling it low through an open-drain enable. The storage is an internal byte array. Its total size, page size, 7-bit device address and word-address length (one or two bytes) are all parameters.

A write transaction gives the word address and then any number of data bytes. The first word address fixes a page, and each data byte lands at the next offset inside that page. The offset wraps within the page and never moves into the next one. The bytes are held in a one-page buffer and are copied into the array as a group when the transaction ends, either with a stop or with a repeated start.

Reads come in three forms: from the current pointer, after a dummy write that loads the pointer (random read), and sequentially through as many bytes as the master acknowledges. A sequential read crosses page boundaries freely and wraps only past the last byte of the array. Every data byte travels on the bus pins, so there is no parallel stream interface to apply back-pressure to: the master paces every transfer with its own clock.

Top module: `eep_target`

## Requirements
- R1: After reset the target leaves the data line released, every byte of the array reads 0x00, and the address pointer is 0.
- R2: A first byte whose upper seven bits equal DEV_ADDR (default 7'h50) is acknowledged by holding the data line low during the ninth clock. Its last bit selects the direction: 0 for write, 1 for read.
- R3: A first byte whose address does not match gets no acknowledge. Every byte after it, up to the next start condition, is ignored and also gets no acknowledge, even one that looks like a matching address.
- R4: In a write, the word address follows as ADDR_BYTES bytes (default 2), most significant byte first. Only its low log2(MEM_BYTES) bits select a location.
- R5: Every byte of a write transaction is acknowledged, including the last data byte before the stop: the device address, each word-address byte and each data byte.
- R6: The page (word address divided by PAGE_BYTES, default 16) is fixed by the word address. Each data byte goes to the current in-page offset, and then only the offset advances, wrapping to 0 at the end of the page.
- R7: Written bytes become visible in the array when a stop or a repeated start ends the write. Bytes of the page that were not written keep their old value.
- R8: A random read is a write of the word address followed by a repeated start and a read-direction address byte. It returns the byte at that word address.
- R9: During a read, the pointer advances after every byte across page boundaries. After location MEM_BYTES-1 (default 511) it wraps to 0.
- R10: When the master does not acknowledge a read byte, the target keeps the data line released until the next start or stop.
- R11: A read-direction access with no word address starts at the pointer left by the last access. After a read this is the location after the last byte sent. After a write it is the next in-page location of that page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| sda_oe | output | 1 | When high, the data line is pulled low |

## Verification
The bench plays the bus master against a byte-level model of the array and pointer.

Single-byte writes at two addresses that differ only in the high address byte show that both address bytes are decoded. A page write that starts four bytes before the page end shows that the offset wraps within the page and does not spill into the next one. A byte written beforehand in the same page shows that unwritten bytes survive the commit.

A write ended by a repeated start instead of a stop confirms the second commit path. A read straddling the array end separates wrapping at capacity from wrapping at the page. A wrong device address followed by a byte that looks like the right one checks that the target stays silent until a new start.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_WADDR,
    ST_ACK_WA,
    ST_WDATA,
    ST_ACK_WD,
    ST_RD,
    ST_RACK,
    ST_RLOAD
  } eep_state_e;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;
  logic [LINES-1:0] raw, st1, st2, st3;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1[g] <= 1'b1;
        st2[g] <= 1'b1;
        st3[g] <= 1'b1;
      end else begin
        st1[g] <= raw[g];
        st2[g] <= st1[g];
        st3[g] <= st2[g];
      end
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now   = st2[1];
  assign scl_old   = st3[1];
  assign sda_s     = st2[0];
  assign sda_old   = st3[0];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/eep_page_store.sv
module eep_page_store #(
  parameter int MEM_BYTES  = 512,
  parameter int PAGE_BYTES = 16,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int OW  = $clog2(PAGE_BYTES),
  localparam int PGW = AW - OW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [OW-1:0]  wr_off,
  input  logic [7:0]     wr_data,
  input  logic           commit,
  input  logic [PGW-1:0] page,
  input  logic [AW-1:0]  rd_addr,
  output logic [7:0]     rd_data
);
  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] dirty;

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= 8'h00;
      dirty <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (dirty[i]) mem[{page, OW'(i)}] <= pbuf[i];
      dirty <= '0;
    end else if (wr_en) begin
      pbuf[wr_off]  <= wr_data;
      dirty[wr_off] <= 1'b1;
    end
  end

  // R7: a commit leaves no byte pending
  p_commit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (dirty == '0));

  // R6: a buffered byte is marked at its in-page offset
  p_mark_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit) |=> dirty[$past(wr_off)]);
endmodule

// File: rtl/eep_target.sv
module eep_target
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         MEM_BYTES  = 512,
  parameter int         PAGE_BYTES = 16,
  parameter int         ADDR_BYTES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int AW  = $clog2(MEM_BYTES);
  localparam int OW  = $clog2(PAGE_BYTES);
  localparam int PGW = AW - OW;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_state_e     state;
  logic [3:0]     cnt;
  logic [7:0]     sh, tx, ahi;
  logic [1:0]     abyte;
  logic           rw, pend;
  logic [AW-1:0]  ptr, ptr_next, wa;
  logic [PGW-1:0] page;
  logic [OW-1:0]  off;
  logic [15:0]    addr_full;
  logic [7:0]     rd_data;
  logic           wr_en, commit, byte_in, last_abyte;

  assign addr_full  = (ADDR_BYTES == 2) ? {ahi, sh} : {8'h00, sh};
  assign wa         = addr_full[AW-1:0];
  assign ptr_next   = (ptr == AW'(MEM_BYTES - 1)) ? '0 : ptr + 1'b1;
  assign byte_in    = scl_fall && (cnt == 4'd8);
  assign wr_en      = (state == ST_WDATA) && byte_in;
  assign commit     = pend && (start_det || stop_det);
  assign last_abyte = (abyte == 2'(ADDR_BYTES - 1));

  eep_page_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(off), .wr_data(sh),
    .commit(commit), .page(page), .rd_addr(ptr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (commit) pend <= 1'b0;
    else if (wr_en) pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ahi    <= '0;
      abyte  <= '0;
      rw     <= 1'b0;
      ptr    <= '0;
      page   <= '0;
      off    <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEV;
      cnt    <= '0;
      abyte  <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (byte_in) begin
            if (state == ST_DEV) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                state  <= ST_ACK_DEV;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK_WA;
              abyte  <= abyte + 1'b1;
              if (last_abyte) begin
                ptr  <= wa;
                page <= wa[AW-1:OW];
                off  <= wa[OW-1:0];
              end else begin
                ahi <= sh;
              end
            end else begin
              sda_oe <= 1'b1;
              off    <= off + 1'b1;
              ptr    <= {page, off + 1'b1};
              state  <= ST_ACK_WD;
            end
          end
        end
        ST_ACK_DEV, ST_RLOAD: begin
          if (scl_fall) begin
            if (state == ST_RLOAD || rw) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= 4'd1;
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WADDR;
            end
          end
        end
        ST_ACK_WA, ST_ACK_WD: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= (state == ST_ACK_WD || abyte == 2'(ADDR_BYTES)) ? ST_WDATA : ST_WADDR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_next;
              state  <= ST_RACK;
            end else begin
              sda_oe <= ~tx[3'd7 - cnt[2:0]];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) state <= sda_s ? ST_IDLE : ST_RLOAD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the line is only pulled while acknowledging or sending read data
  p_oe_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {ST_ACK_DEV, ST_ACK_WA, ST_ACK_WD, ST_RD}));

  // R3: a foreign device address leaves the target idle and silent
  p_mismatch_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && byte_in && sh[7:1] != DEV_ADDR && !start_det && !stop_det)
      |=> (state == ST_IDLE && !sda_oe));

  // R6: a data byte keeps the page and steps only the offset
  p_page_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (page == $past(page) && off == OW'($past(off) + 1'b1)));

  // R9: the read pointer wraps at the last location of the array
  p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && byte_in && ptr == AW'(MEM_BYTES - 1)) |=> (ptr == '0));

  // R10: a master NACK returns the target to idle with the line released
  p_nack_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK && scl_rise && sda_s && !start_det && !stop_det)
      |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: tb/eep_target_test.sv
module eep_target_test;
  localparam int CLK_NS = 10;
  localparam int MEM    = 512;
  localparam int PG     = 16;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = ~(m_low | sda_oe);

  always #(CLK_NS / 2) clk = ~clk;

  eep_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] ref_mem [MEM];
  int ref_ptr = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] got_b;
  event       got_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each byte the target sends with the scoreboard head
  always begin
    @(got_ev);
    if (exp_q.size() == 0) chk(0, "scoreboard-empty", got_b, 0);
    else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(got_b == e, t, got_b, e);
    end
  end

  task automatic wq();
    repeat (5) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 0; wq(); scl = 1; wq(); m_low = 1; wq(); scl = 0; wq();
  endtask

  task automatic bus_stop();
    m_low = 1; wq(); scl = 1; wq(); m_low = 0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
    m_low = 0; wq(); scl = 1; wq(); nack = sda_line; wq(); scl = 0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic line_at_ack);
    m_low = 0;
    for (int i = 7; i >= 0; i--) begin
      wq(); wq(); scl = 1; wq(); b[i] = sda_line; wq(); scl = 0;
    end
    wq(); m_low = give_ack; wq(); scl = 1; wq(); line_at_ack = sda_line; wq(); scl = 0; wq();
  endtask

  task automatic send_acked(input logic [7:0] b, input string tag);
    logic n;
    send_byte(b, n);
    chk(n == 1'b0, tag, n, 0);
  endtask

  task automatic send_addr(input int a);
    send_acked(8'((a >> 8) & 8'hFF), "R4 high address byte ack");
    send_acked(8'(a & 8'hFF), "R4 low address byte ack");
  endtask

  task automatic wr_seq(input int a, input int n, input logic [7:0] base, input bit do_stop);
    int pbase, off;
    pbase = (a % MEM) & ~(PG - 1);
    off   = (a % MEM) % PG;
    bus_start();
    send_acked({DEV, 1'b0}, "R2 write address ack");
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = base + 8'(i * 7);
      send_acked(d, "R5 data byte ack");
      ref_mem[pbase + ((off + i) % PG)] = d;
    end
    ref_ptr = pbase + ((off + n) % PG);
    if (do_stop) bus_stop();
  endtask

  task automatic read_bytes(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      logic line;
      exp_q.push_back(ref_mem[(ref_ptr + i) % MEM]);
      tag_q.push_back(tag);
      recv_byte(i < n - 1, b, line);
      got_b = b;
      ->got_ev;
      if (i == n - 1) chk(line == 1'b1, "R10 line released at master NACK", line, 1);
    end
    ref_ptr = (ref_ptr + n) % MEM;
    bus_stop();
  endtask

  task automatic rd_random(input int a, input int n, input string tag);
    bus_start();
    send_acked({DEV, 1'b0}, "R8 dummy write ack");
    send_addr(a);
    ref_ptr = a % MEM;
    bus_start();
    send_acked({DEV, 1'b1}, "R2 read address ack");
    read_bytes(n, tag);
  endtask

  task automatic rd_current(input int n, input string tag);
    bus_start();
    send_acked({DEV, 1'b1}, "R2 read address ack");
    read_bytes(n, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MEM; i++) ref_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: line released and array empty after reset
    chk(sda_line == 1'b1, "R1 line released after reset", sda_line, 1);
    rd_current(2, "R1 R11 reset contents from pointer 0");

    // R5 R8: single byte write, then random read of it
    wr_seq(16'h0005, 1, 8'hA5, 1);
    rd_random(16'h0005, 1, "R8 random read of written byte");

    // R4: high address byte separates 0x105 from 0x005
    wr_seq(16'h0105, 1, 8'h3C, 1);
    rd_random(16'h0005, 1, "R4 low location untouched");
    rd_random(16'h0105, 1, "R4 high location written");

    // R6 R7: page write wrapping inside page 0x010, one byte preset
    wr_seq(16'h0018, 1, 8'h5A, 1);
    wr_seq(16'h001C, 8, 8'h40, 1);
    rd_current(1, "R11 pointer after page write");
    rd_random(16'h0010, 17, "R6 R7 page contents and next page");

    // R7: write ended by a repeated start
    wr_seq(16'h0030, 2, 8'h11, 0);
    rd_random(16'h0030, 2, "R7 commit at repeated start");

    // R9: read across the end of the array
    wr_seq(16'h01FF, 1, 8'h77, 1);
    rd_random(16'h01FE, 3, "R9 wrap at capacity");
    rd_current(1, "R11 pointer after wrapping read");

    // R3: foreign address, then a byte resembling the right one
    begin
      logic n;
      bus_start();
      send_byte({7'h51, 1'b0}, n);
      chk(n == 1'b1, "R3 foreign address not acked", n, 1);
      send_byte({DEV, 1'b0}, n);
      chk(n == 1'b1, "R3 later byte ignored", n, 1);
      send_byte(8'h99, n);
      chk(n == 1'b1, "R3 data ignored", n, 1);
      bus_stop();
    end
    rd_random(16'h0005, 1, "R3 array unchanged");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule